// File: doc/BRIEF.md
# Match-Compare Watchdog Timer

This block is a register-mapped watchdog timer. A 32-bit up-counter runs on the timer clock and is compared with a programmable match value. On an equality hit, a set of independently enabled actions can follow. It can raise an interrupt, return the counter to zero, or halt counting. It can also start a reset pulse whose length is programmable, and that pulse can drive an internal reset request, an external reset line, or both. A separate match pin can be driven low, driven high or toggled on each hit.

Software restarts the timer by requesting a counter clear and polling the counter register until it reads zero. It then sets the enable bit again. A debug-halt input can freeze counting when software allows it. A sticky status bit records that the internal reset request fired. This bit is cleared only by the power-on reset input, so it survives the system reset that the watchdog itself causes.

Top module: `wdt_match_timer`

## Requirements
- R1: After `rst_n` or `por_n` goes low, every register except the reset status reads 0, the counter reads 0, and `irq`, `wd_rst_int`, `wd_rst_ext` and `match_pin` are low.
- R2: Control bit 0 (offset 0x04) makes the counter (offset 0x08) advance by one per clock. Writing 0 to control stops the counter and holds its value.
- R3: While control bit 1 is set, the counter reads 0 from the next cycle on and does not count. This lets software poll for zero.
- R4: With control bit 2 set, a high `dbg_halt` freezes the counter. With bit 2 clear, `dbg_halt` has no effect.
- R5: A hit happens when counting is enabled and the counter equals the match value (offset 0x10). If match-control (offset 0x0C) bit 0 is set, a hit sets the pending interrupt. The pending interrupt drives `irq` and reads as bit 0 of offset 0x00. Writing 1 to that bit clears it, and writing 0 does nothing.
- R6: When match-control bit 1 is set, a hit returns the counter to 0. When match-control bit 2 is set, a hit clears control bit 0 and the counter holds at the match value. Without either bit, the counter moves on past the match value.
- R7: When match-control bit 3 or bit 4 is set, a hit starts a reset pulse. The pulse lasts the pulse-length value (offset 0x18, 16 bits) plus 6 clock cycles, so 0xFFFF gives 65541 cycles. It appears on `wd_rst_int` if bit 3 is set and on `wd_rst_ext` if bit 4 is set.
- R8: While match-control bit 5 is set, `wd_rst_int` is high. While bit 6 is set, `wd_rst_ext` is high.
- R9: Bits 5:4 of the external-match register (offset 0x14) choose the pin action on a hit: 0 keep, 1 low, 2 high, 3 toggle. Bit 0 reads the `match_pin` state and can be written directly.
- R10: Bit 0 of offset 0x1C becomes 1 once `wd_rst_int` has been high. Writes do not change it, `rst_n` does not clear it, and only `por_n` does.
- R11: The match register holds any 32-bit value, including 780000000 (60 seconds at 13 MHz). Writes to the counter offset are ignored.
- R12: An address decodes only when it is word aligned (bits 1:0 zero) and below 0x20. Any other address reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and bus clock |
| por_n | input | 1 | Power-on reset, active low, clears everything |
| rst_n | input | 1 | System reset, active low, keeps the reset status |
| bus_addr | input | ADDR_W (6) | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| dbg_halt | input | 1 | Debugger halt indication |
| irq | output | 1 | Pending match interrupt |
| wd_rst_int | output | 1 | Internal reset request |
| wd_rst_ext | output | 1 | External reset output |
| match_pin | output | 1 | External match pin |

## Verification
The bench builds the block with its default parameters: a 6-bit address, a 16-bit pulse length and a pulse extension of 6. Because the full 16-bit pulse range stays at the default, the longest pulse of 65541 cycles is measured end to end. Small match values keep each hit within tens of cycles. The 6-bit address reaches both the unmapped window at 0x20 to 0x3C and unaligned addresses. Random match values near zero, including zero itself, and random combinations of match actions and pin actions are checked against the counter value and pin state that a bench function predicts at the first hit.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int REG_W = 32;

    typedef enum logic [2:0] {
        OFS_INT   = 3'd0,
        OFS_CTRL  = 3'd1,
        OFS_CNT   = 3'd2,
        OFS_MCTRL = 3'd3,
        OFS_MATCH = 3'd4,
        OFS_EXT   = 3'd5,
        OFS_PULSE = 3'd6,
        OFS_RSTAT = 3'd7
    } reg_sel_e;

    typedef enum logic [1:0] {
        PIN_KEEP   = 2'd0,
        PIN_LOW    = 2'd1,
        PIN_HIGH   = 2'd2,
        PIN_TOGGLE = 2'd3
    } pin_act_e;

    // control word, bit 0 is run
    typedef struct packed {
        logic halt_on_dbg;
        logic clr;
        logic run;
    } ctrl_t;

    // match actions, bit 0 is irq_en
    typedef struct packed {
        logic force_ext;
        logic force_int;
        logic rst_ext_en;
        logic rst_int_en;
        logic stop_on_hit;
        logic zero_on_hit;
        logic irq_en;
    } mctrl_t;
endpackage

// File: rtl/wdt_count.sv
module wdt_count #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         clr,
    input  logic         zero_on_hit,
    input  logic         stop_on_hit,
    input  logic [W-1:0] match_val,
    output logic [W-1:0] cnt_q,
    output logic         hit
);
    logic [W-1:0] cnt_d;

    always_comb begin
        hit   = run && !clr && (cnt_q == match_val);
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (hit) begin
            if (zero_on_hit)
                cnt_d = '0;
            else if (!stop_on_hit)
                cnt_d = cnt_q + W'(1);
        end else if (run) begin
            cnt_d = cnt_q + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
    parameter int LEN_W = 16,
    parameter int EXTRA = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [LEN_W-1:0] len,
    output logic             active
);
    localparam int CW = LEN_W + 1;

    logic [CW-1:0] remain_d, remain_q;

    always_comb begin
        remain_d = remain_q;
        if (remain_q != '0)
            remain_d = remain_q - CW'(1);
        else if (fire)
            remain_d = {1'b0, len} + CW'(EXTRA);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) remain_q <= '0;
        else        remain_q <= remain_d;
    end

    assign active = (remain_q != '0);
endmodule

// File: rtl/wdt_match_timer.sv
module wdt_match_timer
    import wdt_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int PULSE_W     = 16,
    parameter int PULSE_EXTRA = 6
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              dbg_halt,
    output logic              irq,
    output logic              wd_rst_int,
    output logic              wd_rst_ext,
    output logic              match_pin
);
    localparam int SEL_LSB = 2;
    localparam int SEL_W   = 3;
    localparam int HI_LSB  = SEL_LSB + SEL_W;

    typedef struct packed {
        ctrl_t              ctrl;
        mctrl_t             mctrl;
        logic [REG_W-1:0]   match;
        pin_act_e           act;
        logic               pin;
        logic [PULSE_W-1:0] plen;
        logic               pend;
    } regs_t;

    regs_t            r_d, r_q;
    logic             stat_d, stat_q;
    logic             sys_rst_n;
    reg_sel_e         sel;
    logic             aligned, in_map;
    logic             cnt_run, hit, fire, pulse_on;
    logic [REG_W-1:0] cnt;

    assign sys_rst_n = rst_n & por_n;
    assign sel       = reg_sel_e'(bus_addr[HI_LSB-1:SEL_LSB]);
    assign aligned   = (bus_addr[SEL_LSB-1:0] == '0);

    generate
        if (ADDR_W > HI_LSB) begin : g_hi_dec
            assign in_map = aligned && (bus_addr[ADDR_W-1:HI_LSB] == '0);
        end else begin : g_full_dec
            assign in_map = aligned;
        end
    endgenerate

    assign cnt_run = r_q.ctrl.run & ~(r_q.ctrl.halt_on_dbg & dbg_halt);
    assign fire    = hit & (r_q.mctrl.rst_int_en | r_q.mctrl.rst_ext_en);

    wdt_count #(.W(REG_W)) u_count (
        .clk         (clk),
        .rst_n       (sys_rst_n),
        .run         (cnt_run),
        .clr         (r_q.ctrl.clr),
        .zero_on_hit (r_q.mctrl.zero_on_hit),
        .stop_on_hit (r_q.mctrl.stop_on_hit),
        .match_val   (r_q.match),
        .cnt_q       (cnt),
        .hit         (hit)
    );

    wdt_pulse #(.LEN_W(PULSE_W), .EXTRA(PULSE_EXTRA)) u_pulse (
        .clk    (clk),
        .rst_n  (sys_rst_n),
        .fire   (fire),
        .len    (r_q.plen),
        .active (pulse_on)
    );

    // next-state for the register file
    always_comb begin
        r_d = r_q;
        if (bus_we && in_map) begin
            case (sel)
                OFS_INT:   if (bus_wdata[0]) r_d.pend = 1'b0;
                OFS_CTRL:  r_d.ctrl  = ctrl_t'(bus_wdata[2:0]);
                OFS_MCTRL: r_d.mctrl = mctrl_t'(bus_wdata[6:0]);
                OFS_MATCH: r_d.match = bus_wdata;
                OFS_EXT: begin
                    r_d.pin = bus_wdata[0];
                    r_d.act = pin_act_e'(bus_wdata[5:4]);
                end
                OFS_PULSE: r_d.plen = bus_wdata[PULSE_W-1:0];
                default: ;
            endcase
        end
        if (hit) begin
            if (r_q.mctrl.stop_on_hit) r_d.ctrl.run = 1'b0;
            if (r_q.mctrl.irq_en)      r_d.pend     = 1'b1;
            case (r_q.act)
                PIN_LOW:    r_d.pin = 1'b0;
                PIN_HIGH:   r_d.pin = 1'b1;
                PIN_TOGGLE: r_d.pin = ~r_q.pin;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge sys_rst_n) begin
        if (!sys_rst_n) r_q <= '0;
        else            r_q <= r_d;
    end

    assign wd_rst_int = (pulse_on & r_q.mctrl.rst_int_en) | r_q.mctrl.force_int;
    assign wd_rst_ext = (pulse_on & r_q.mctrl.rst_ext_en) | r_q.mctrl.force_ext;
    assign irq        = r_q.pend;
    assign match_pin  = r_q.pin;

    // sticky status, power-on reset only
    assign stat_d = stat_q | wd_rst_int;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) stat_q <= 1'b0;
        else        stat_q <= stat_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (in_map) begin
            case (sel)
                OFS_INT:   bus_rdata[0]         = r_q.pend;
                OFS_CTRL:  bus_rdata[2:0]       = r_q.ctrl;
                OFS_CNT:   bus_rdata            = cnt;
                OFS_MCTRL: bus_rdata[6:0]       = r_q.mctrl;
                OFS_MATCH: bus_rdata            = r_q.match;
                OFS_EXT:   bus_rdata[5:0]       = {r_q.act, 3'b000, r_q.pin};
                OFS_PULSE: bus_rdata[PULSE_W-1:0] = r_q.plen;
                OFS_RSTAT: bus_rdata[0]         = stat_q;
                default:   bus_rdata            = '0;
            endcase
        end
    end
endmodule

// File: rtl/wdt_chk.sv
module wdt_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        por_n,
    input logic        ctrl_run,
    input logic        ctrl_clr,
    input logic        halt_en,
    input logic        dbg_halt,
    input logic [31:0] cnt,
    input logic        hit,
    input logic        irq_en,
    input logic        irq,
    input logic [1:0]  act,
    input logic        pin,
    input logic        rst_int,
    input logic        status
);
    // R3: a pending clear yields a zero counter next cycle
    a_r3_clr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_clr |=> (cnt == 32'd0));

    // R2: with counting off the value is held
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_run && !ctrl_clr) |=> $stable(cnt));

    // R4: debug halt freezes when allowed
    a_r4_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_run && halt_en && dbg_halt && !ctrl_clr) |=> $stable(cnt));

    // R5: an enabled hit raises the interrupt
    a_r5_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && irq_en) |=> irq);

    // R9: drive-high and drive-low pin actions
    a_r9_pin_high: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && act == 2'd2) |=> pin);
    a_r9_pin_low: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && act == 2'd1) |=> !pin);

    // R10: status is set by the internal reset and stays set
    a_r10_set: assert property (@(posedge clk) disable iff (!por_n)
        rst_int |=> status);
    a_r10_sticky: assert property (@(posedge clk) disable iff (!por_n)
        status |=> status);
endmodule

bind wdt_match_timer wdt_chk u_chk (
    .clk      (clk),
    .rst_n    (sys_rst_n),
    .por_n    (por_n),
    .ctrl_run (r_q.ctrl.run),
    .ctrl_clr (r_q.ctrl.clr),
    .halt_en  (r_q.ctrl.halt_on_dbg),
    .dbg_halt (dbg_halt),
    .cnt      (cnt),
    .hit      (hit),
    .irq_en   (r_q.mctrl.irq_en),
    .irq      (irq),
    .act      (r_q.act),
    .pin      (match_pin),
    .rst_int  (wd_rst_int),
    .status   (stat_q)
);

// File: tb/wdt_match_timer_tb.sv
module wdt_match_timer_tb;
    localparam logic [5:0] A_INT = 6'h00, A_CTRL = 6'h04, A_CNT = 6'h08, A_MCTRL = 6'h0C,
                           A_MATCH = 6'h10, A_EXT = 6'h14, A_PULSE = 6'h18, A_RSTAT = 6'h1C;

    logic        clk = 1'b0;
    logic        por_n = 1'b0, rst_n = 1'b0;
    logic [5:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0, rdata;
    logic        dbg_halt = 1'b0;
    logic        irq, rst_int, rst_ext, pin;
    int          tests = 0, fails = 0;
    logic        done = 1'b0;

    always #5 clk = ~clk;

    wdt_match_timer u_dut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
        .bus_wdata(wdata), .bus_rdata(rdata), .dbg_halt(dbg_halt), .irq(irq),
        .wd_rst_int(rst_int), .wd_rst_ext(rst_ext), .match_pin(pin)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; we = 1'b1; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    function automatic logic [31:0] exp_cnt(input logic [31:0] m, input logic zero, input logic stop);
        if (zero) return 32'd0;
        if (stop) return m;
        return m + 32'd1;
    endfunction

    function automatic logic exp_pin(input logic [1:0] act, input logic p0);
        case (act)
            2'd1:    return 1'b0;
            2'd2:    return 1'b1;
            2'd3:    return ~p0;
            default: return p0;
        endcase
    endfunction

    // clear, program and start; returns cycles until irq
    task automatic arm(input logic [31:0] m, input logic [6:0] mc, input logic [5:0] ext, output int n);
        wr(A_CTRL, 32'h2);
        wr(A_INT, 32'h1);
        wr(A_MCTRL, {25'd0, mc});
        wr(A_MATCH, m);
        wr(A_EXT, {26'd0, ext});
        wr(A_CTRL, 32'h1);
        n = 0;
        while (!irq && !rst_ext && n < 400) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int n;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        por_n = 1'b1; rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int i = 0; i < 8; i++) begin
            rd(6'(i * 4), v);
            chk("R1 register zero", v, 32'd0);
        end
        chk("R1 outputs low", {28'd0, irq, rst_int, rst_ext, pin}, 32'd0);

        // R11 counter offset read-only, wide match value
        wr(A_CNT, 32'd77);
        rd(A_CNT, v); chk("R11 counter write ignored", v, 32'd0);
        wr(A_MATCH, 32'd780000000);
        rd(A_MATCH, v); chk("R11 match holds 60s at 13MHz", v, 32'd780000000);

        // R12 unmapped and unaligned
        wr(6'h24, 32'h1);
        rd(A_CTRL, v); chk("R12 high alias ignored", v, 32'd0);
        rd(6'h30, v); chk("R12 unmapped reads zero", v, 32'd0);
        rd(6'h11, v); chk("R12 unaligned reads zero", v, 32'd0);
        wr(6'h12, 32'h5);
        rd(A_MATCH, v); chk("R12 unaligned write ignored", v, 32'd780000000);

        // R3 clear handshake, R2 counting and hold
        wr(A_CTRL, 32'h2);
        @(negedge clk);
        rd(A_CNT, v); chk("R3 counter zero after clear", v, 32'd0);
        wr(A_CTRL, 32'h1);
        repeat (10) @(negedge clk);
        rd(A_CNT, v); chk("R2 counts one per clock", v, 32'd10);
        wr(A_CTRL, 32'h0);
        repeat (5) @(negedge clk);
        rd(A_CNT, v); chk("R2 hold after stop", v, 32'd12);

        // R4 debug halt
        dbg_halt = 1'b1;
        wr(A_CTRL, 32'h5);
        repeat (8) @(negedge clk);
        rd(A_CNT, v); chk("R4 frozen by halt", v, 32'd12);
        dbg_halt = 1'b0;
        repeat (5) @(negedge clk);
        rd(A_CNT, v); chk("R4 resumes", v, 32'd17);
        wr(A_CTRL, 32'h1);
        dbg_halt = 1'b1;
        repeat (5) @(negedge clk);
        rd(A_CNT, v); chk("R4 halt ignored without bit 2", v, 32'd24);
        dbg_halt = 1'b0;

        // R5/R6 directed: irq + stop, then W1C
        arm(32'd7, 7'h05, 6'h00, n);
        chk("R5 hit timing", n, 32'd8);
        rd(A_CNT, v); chk("R6 stop holds at match", v, 32'd7);
        rd(A_CTRL, v); chk("R6 stop clears enable", v, 32'd0);
        rd(A_INT, v); chk("R5 pending reads 1", v, 32'd1);
        wr(A_INT, 32'h0);
        chk("R5 write 0 keeps irq", {31'd0, irq}, 32'd1);
        wr(A_INT, 32'h1);
        chk("R5 W1C clears irq", {31'd0, irq}, 32'd0);

        // R9 direct pin write
        wr(A_EXT, 32'h1);
        rd(A_EXT, v); chk("R9 pin readback", v, 32'h1);
        chk("R9 pin output", {31'd0, pin}, 32'd1);

        // R5/R6/R9 random
        for (int k = 0; k < 24; k++) begin
            logic [31:0] m;
            logic z, s, p0;
            logic [1:0] act;
            m = $urandom % 40;
            z = 1'($urandom); s = 1'($urandom);
            act = 2'($urandom); p0 = 1'($urandom);
            arm(m, {4'd0, s, z, 1'b1}, {act, 3'b000, p0}, n);
            chk("R5 random hit timing", n, m + 32'd1);
            rd(A_CNT, v); chk("R6 random counter after hit", v, exp_cnt(m, z, s));
            chk("R9 random pin action", {31'd0, pin}, {31'd0, exp_pin(act, p0)});
            if (s) begin
                repeat (3) @(negedge clk);
                rd(A_CNT, v); chk("R6 random stop stays", v, exp_cnt(m, z, s));
            end
        end

        // R7 external pulse, short length
        wr(A_PULSE, 32'd10);
        arm(32'd5, 7'h14, 6'h00, n);
        chk("R7 ext pulse starts after hit", n, 32'd6);
        n = 0;
        while (rst_ext && n < 70000) begin
            n++;
            chk("R7 int stays low", {31'd0, rst_int}, 32'd0);
            @(negedge clk);
        end
        chk("R7 pulse len+6", n, 32'd16);
        rd(A_RSTAT, v); chk("R10 no status without internal reset", v, 32'd0);

        // R7 longest pulse on internal reset
        wr(A_PULSE, 32'hFFFF);
        wr(A_CTRL, 32'h2);
        wr(A_MCTRL, 32'h0C);
        wr(A_MATCH, 32'd3);
        wr(A_CTRL, 32'h1);
        n = 0;
        while (!rst_int && n < 100) begin @(negedge clk); n++; end
        n = 0;
        while (rst_int && n < 70000) begin n++; @(negedge clk); end
        chk("R7 longest pulse 65541", n, 32'd65541);
        rd(A_RSTAT, v); chk("R10 status set", v, 32'd1);
        wr(A_RSTAT, 32'h0);
        rd(A_RSTAT, v); chk("R10 status write ignored", v, 32'd1);

        // R8 forced outputs
        wr(A_MCTRL, 32'h20);
        chk("R8 force internal", {30'd0, rst_int, rst_ext}, 32'h2);
        wr(A_MCTRL, 32'h40);
        chk("R8 force external", {30'd0, rst_int, rst_ext}, 32'h1);
        wr(A_MCTRL, 32'h0);
        chk("R8 release", {30'd0, rst_int, rst_ext}, 32'h0);

        // R1/R10 system reset keeps status
        wr(A_MATCH, 32'h1234);
        wr(A_CTRL, 32'h1);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        rd(A_MATCH, v); chk("R1 match cleared by rst_n", v, 32'd0);
        rd(A_CNT, v); chk("R1 counter cleared by rst_n", v, 32'd0);
        rd(A_RSTAT, v); chk("R10 status survives rst_n", v, 32'd1);
        @(negedge clk); por_n = 1'b0;
        repeat (2) @(negedge clk); por_n = 1'b1;
        rd(A_RSTAT, v); chk("R10 status cleared by por_n", v, 32'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule